// File: doc/BRIEF.md
# Paged Byte-Wide Boot Loader

This block fills on-chip program RAM from an external memory that is eight bits wide. The external space holds 64K bytes in eight pages of 8K bytes. A 3-bit page number picks the page to load. The block reads a fixed number of bytes from the start of that page and writes them into RAM as 24-bit words. The number of words is a parameter. Each word takes three bytes, and the first byte read becomes the most significant byte.

Loading begins in two ways. It starts on its own from page 0 in the first cycle after reset, if the memory-map input is low and no bus request is pending. Software can also start a load by setting a force bit, and that bit clears itself when the load starts.

Each read drives the 16-bit byte address on two sets of pins: the low 14 bits on the address bus and the top two bits on the two upper data pins. The boot-select and read strobes stay asserted for a programmable number of wait states plus one cycle. Between reads, an external master can take the bus with a request and grant handshake. When the last word reaches RAM, the block raises a done pulse and releases the core, which then runs from program address 0.

Top module: `boot_loader`

## Requirements
- R1: In the first cycle after reset is released, if `mmap_sel` is 0 and `bus_req` is 0, the block loads page 0. Byte offset k of the page is read from boot address k.
- R2: If `mmap_sel` is 1, or `bus_req` is 1, when reset is released, no boot read happens. `exec_en` is 1 from the second cycle after reset release.
- R3: A pulse on `force_set` starts one load of the page given by `page_sel`. The force bit clears when the load starts, so a single pulse produces a single load.
- R4: Byte i of a load has the boot address {page[2:0], i[12:0]}. Bits 13:0 of that address are driven on `ext_addr` and bits 15:14 on `ext_addr_hi`. i counts up from 0.
- R5: Each read holds `boot_sel_n` and `rd_n` both low for exactly W+1 cycles, where W is the wait-state setting. `boot_byte` is sampled in the last of those cycles. W resets to 7, and a pulse on `ws_we` loads it from `ws_val`.
- R6: Bytes 3k, 3k+1 and 3k+2 of a load form one word {b0,b1,b2}. That word is written with a one-cycle `pm_we` pulse to `pm_addr` = k, for k = 0 to NUM_WORDS-1.
- R7: A bus request is honoured only between reads. While `bus_grant` is 1 the strobes are high. The load resumes once the request drops, and the loaded words are not affected.
- R8: `boot_done` pulses for one cycle, in the cycle after the last word is written. `exec_en` is 0 from the start of a load until that pulse and 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmap_sel | input | 1 | Memory-map select; 0 enables the boot at reset release |
| bus_req | input | 1 | External bus request |
| bus_grant | output | 1 | External bus grant |
| page_sel | input | 3 | Page number used by a software-forced boot |
| force_set | input | 1 | Sets the self-clearing force bit |
| ws_we | input | 1 | Load strobe for the wait-state setting |
| ws_val | input | 3 | New wait-state setting |
| ext_addr | output | 14 | Boot byte address bits 13:0 |
| ext_addr_hi | output | 2 | Boot byte address bits 15:14, driven on the top data pins |
| boot_sel_n | output | 1 | Boot memory select, active low |
| rd_n | output | 1 | Read strobe, active low |
| boot_byte | input | 8 | Byte read from the upper data byte lane |
| pm_we | output | 1 | Program RAM write enable |
| pm_addr | output | PM_AW | Program RAM word address |
| pm_wdata | output | 24 | Program RAM write data |
| boot_done | output | 1 | One-cycle pulse when the load completes |
| exec_en | output | 1 | Releases the core to run from address 0 |

## Verification
The hardest case to reach is a bus request that arrives in the middle of a load. The handover must happen exactly at a byte boundary, with the strobes released, the byte offset frozen and the partially built word kept, and it must be reached under several wait-state settings. The bench raises `bus_req` at random on many cycles during forced boots of random pages with random wait settings. It then checks every word written, the total number of strobe cycles, and that the grant and the strobes never overlap. Reset with a pending request and reset with the memory map set to 1 are driven as separate directed cases.

// File: rtl/boot_pkg.sv
package boot_pkg;
  typedef enum logic [1:0] {
    ST_CHECK = 2'd0,
    ST_IDLE  = 2'd1,
    ST_READ  = 2'd2,
    ST_HOLD  = 2'd3
  } boot_st_e;

  localparam int unsigned BYTES_PER_WORD = 3;
  localparam int unsigned BYTE_W         = 8;
  localparam int unsigned WORD_W         = BYTES_PER_WORD * BYTE_W;
endpackage

// File: rtl/boot_wait_ctr.sv
module boot_wait_ctr #(
  parameter int unsigned WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [WS_W-1:0] cfg_val,
  input  logic            active,
  output logic            last
);
  logic [WS_W-1:0] wait_q, wait_d;
  logic [WS_W-1:0] cnt_q, cnt_d;

  always_comb begin
    wait_d = wait_q;
    if (cfg_we) wait_d = cfg_val;
  end

  assign last = active && (cnt_q == wait_q);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (!active || last) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '1;
      cnt_q  <= '0;
    end else begin
      wait_q <= wait_d;
      cnt_q  <= cnt_d;
    end
  end

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= wait_q); // R5
endmodule

// File: rtl/boot_addr_gen.sv
module boot_addr_gen #(
  parameter int unsigned PAGE_W = 3,
  parameter int unsigned OFF_W  = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [PAGE_W-1:0]       page_in,
  input  logic                    take,
  output logic [PAGE_W+OFF_W-1:0] addr_o
);
  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFF_W-1:0]  off_q, off_d;

  always_comb begin
    page_d = page_q;
    off_d  = off_q;
    if (start) begin
      page_d = page_in;
      off_d  = '0;
    end else if (take) begin
      off_d  = off_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
    end else begin
      page_q <= page_d;
      off_q  <= off_d;
    end
  end

  assign addr_o = {page_q, off_q};

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !start) |=> (off_q == $past(off_q) + 1'b1)); // R4
endmodule

// File: rtl/boot_word_pack.sv
module boot_word_pack
  import boot_pkg::*;
#(
  parameter int unsigned PM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              pm_we,
  output logic [PM_AW-1:0]  pm_addr,
  output logic [WORD_W-1:0] pm_wdata
);
  localparam int unsigned SH_W  = WORD_W - BYTE_W;
  localparam int unsigned IDX_W = $clog2(BYTES_PER_WORD);

  logic [SH_W-1:0]   sh_q, sh_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [PM_AW-1:0]  widx_q, widx_d;
  logic              we_q, we_d;
  logic [PM_AW-1:0]  addr_q, addr_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic              word_end;

  assign word_end = (idx_q == IDX_W'(BYTES_PER_WORD - 1));

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    widx_d = widx_q;
    we_d   = 1'b0;
    addr_d = addr_q;
    data_d = data_q;
    if (start) begin
      idx_d  = '0;
      widx_d = '0;
    end else if (take) begin
      if (word_end) begin
        we_d   = 1'b1;
        addr_d = widx_q;
        data_d = {sh_q, byte_in};
        widx_d = widx_q + 1'b1;
        idx_d  = '0;
      end else begin
        sh_d   = {sh_q[SH_W-BYTE_W-1:0], byte_in};
        idx_d  = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      widx_q <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      widx_q <= widx_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign pm_we    = we_q;
  assign pm_addr  = addr_q;
  assign pm_wdata = data_q;

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |=> !pm_we); // R6
endmodule

// File: rtl/boot_loader.sv
module boot_loader
  import boot_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 32,
  parameter int unsigned PM_AW     = 11,
  parameter int unsigned PAGE_W    = 3,
  parameter int unsigned OFF_W     = 13,
  parameter int unsigned EXT_AW    = 14,
  parameter int unsigned WS_W      = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           mmap_sel,
  input  logic                           bus_req,
  output logic                           bus_grant,
  input  logic [PAGE_W-1:0]              page_sel,
  input  logic                           force_set,
  input  logic                           ws_we,
  input  logic [WS_W-1:0]                ws_val,
  output logic [EXT_AW-1:0]              ext_addr,
  output logic [PAGE_W+OFF_W-EXT_AW-1:0] ext_addr_hi,
  output logic                           boot_sel_n,
  output logic                           rd_n,
  input  logic [7:0]                     boot_byte,
  output logic                           pm_we,
  output logic [PM_AW-1:0]               pm_addr,
  output logic [23:0]                    pm_wdata,
  output logic                           boot_done,
  output logic                           exec_en
);
  localparam int unsigned ADDR_W      = PAGE_W + OFF_W;
  localparam int unsigned TOTAL_BYTES = NUM_WORDS * BYTES_PER_WORD;

  boot_st_e          st_q, st_d;
  logic              force_q, force_d;
  logic              busy_q, busy_d;
  logic              exec_q, exec_d;
  logic              done_q, done_d;
  logic              start;
  logic [PAGE_W-1:0] start_page;
  logic              reading;
  logic              take;
  logic              last_byte;
  logic [ADDR_W-1:0] baddr;

  assign reading   = (st_q == ST_READ);
  assign last_byte = take && (baddr[OFF_W-1:0] == OFF_W'(TOTAL_BYTES - 1));

  always_comb begin
    st_d       = st_q;
    start      = 1'b0;
    start_page = page_sel;
    busy_d     = busy_q;
    exec_d     = exec_q;
    case (st_q)
      ST_CHECK: begin
        if (!mmap_sel && !bus_req) begin
          start      = 1'b1;
          start_page = '0;
          st_d       = ST_READ;
        end else begin
          exec_d     = 1'b1;
          st_d       = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (bus_req) begin
          st_d  = ST_HOLD;
        end else if (force_q) begin
          start = 1'b1;
          st_d  = ST_READ;
        end
      end
      ST_READ: begin
        if (last_byte) begin
          st_d   = ST_IDLE;
          busy_d = 1'b0;
        end else if (take && bus_req) begin
          st_d   = ST_HOLD;
        end
      end
      default: begin
        if (!bus_req) st_d = busy_q ? ST_READ : ST_IDLE;
      end
    endcase
    if (start) begin
      busy_d = 1'b1;
      exec_d = 1'b0;
    end
    if (done_q) exec_d = 1'b1;
  end

  always_comb begin
    force_d = force_q;
    if (start)          force_d = 1'b0;
    else if (force_set) force_d = 1'b1;
  end

  assign done_d = pm_we && (pm_addr == PM_AW'(NUM_WORDS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_CHECK;
      force_q <= 1'b0;
      busy_q  <= 1'b0;
      exec_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      force_q <= force_d;
      busy_q  <= busy_d;
      exec_q  <= exec_d;
      done_q  <= done_d;
    end
  end

  boot_wait_ctr #(.WS_W(WS_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .cfg_we(ws_we), .cfg_val(ws_val),
    .active(reading), .last(take)
  );

  boot_addr_gen #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .start(start), .page_in(start_page),
    .take(take), .addr_o(baddr)
  );

  boot_word_pack #(.PM_AW(PM_AW)) u_pack (
    .clk(clk), .rst_n(rst_n), .start(start), .take(take),
    .byte_in(boot_byte), .pm_we(pm_we), .pm_addr(pm_addr),
    .pm_wdata(pm_wdata)
  );

  assign ext_addr    = baddr[EXT_AW-1:0];
  assign ext_addr_hi = baddr[ADDR_W-1:EXT_AW];
  assign boot_sel_n  = !reading;
  assign rd_n        = !reading;
  assign bus_grant   = (st_q == ST_HOLD);
  assign boot_done   = done_q;
  assign exec_en     = exec_q;

  AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> (boot_sel_n && rd_n)); // R7
  AST_FORCE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !force_set) |=> !force_q); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> !boot_done); // R8
  AST_EXEC_OFF_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_sel_n |-> !exec_en); // R8
endmodule

// File: tb/boot_loader_tb.sv
module boot_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 32;
  localparam int AW         = 11;

  logic        clk;
  logic        rst_n;
  logic        mmap_sel;
  logic        bus_req;
  logic        bus_grant;
  logic [2:0]  page_sel;
  logic        force_set;
  logic        ws_we;
  logic [2:0]  ws_val;
  logic [13:0] ext_addr;
  logic [1:0]  ext_addr_hi;
  logic        boot_sel_n;
  logic        rd_n;
  logic [7:0]  boot_byte;
  logic        pm_we;
  logic [AW-1:0] pm_addr;
  logic [23:0] pm_wdata;
  logic        boot_done;
  logic        exec_en;

  logic        noise_en;
  logic        noise_req;
  logic        forced_req;

  int n_run;
  int n_fail;
  int strobe_cnt;
  int done_cnt;
  int grant_cnt;
  int overlap_cnt;
  int split_cnt;
  int exec_bad;
  int bad_addr;
  logic [23:0] got_w [N];
  bit          got_v [N];
  bit          finished;

  boot_loader #(.NUM_WORDS(N), .PM_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mmap_sel(mmap_sel), .bus_req(bus_req),
    .bus_grant(bus_grant), .page_sel(page_sel), .force_set(force_set),
    .ws_we(ws_we), .ws_val(ws_val), .ext_addr(ext_addr),
    .ext_addr_hi(ext_addr_hi), .boot_sel_n(boot_sel_n), .rd_n(rd_n),
    .boot_byte(boot_byte), .pm_we(pm_we), .pm_addr(pm_addr),
    .pm_wdata(pm_wdata), .boot_done(boot_done), .exec_en(exec_en)
  );

  function automatic logic [7:0] mem_f(input int a);
    return 8'(((a * 29) ^ (a >> 5) ^ (a >> 11)) & 255);
  endfunction

  function automatic logic [23:0] exp_word(input int page, input int k);
    int b;
    b = page * 8192 + 3 * k;
    return {mem_f(b), mem_f(b + 1), mem_f(b + 2)};
  endfunction

  assign boot_byte = mem_f(int'({ext_addr_hi, ext_addr}));
  assign bus_req   = noise_en ? noise_req : forced_req;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    noise_req = 1'b0;
    forever begin
      @(negedge clk);
      noise_req <= ($urandom % 3) == 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!boot_sel_n) strobe_cnt++;
      if (boot_sel_n != rd_n) split_cnt++;
      if (bus_grant) grant_cnt++;
      if (bus_grant && !boot_sel_n) overlap_cnt++;
      if (!boot_sel_n && exec_en) exec_bad++;
      if (boot_done) done_cnt++;
      if (pm_we) begin
        if (int'(pm_addr) < N) begin
          got_w[pm_addr] = pm_wdata;
          got_v[pm_addr] = 1'b1;
        end else bad_addr++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic clear_mon();
    strobe_cnt = 0; done_cnt = 0; grant_cnt = 0; overlap_cnt = 0;
    split_cnt = 0; exec_bad = 0; bad_addr = 0;
    for (int i = 0; i < N; i++) begin
      got_v[i] = 1'b0;
      got_w[i] = '0;
    end
  endtask

  task automatic wait_done(input string req);
    int c;
    c = 0;
    while (done_cnt == 0 && c < 20000) begin
      @(negedge clk);
      c++;
    end
    chk(done_cnt == 1, req, done_cnt, 1);
  endtask

  task automatic check_words(input int page, input string req);
    int bad;
    int first_bad;
    bad = 0;
    first_bad = -1;
    for (int k = 0; k < N; k++) begin
      if (!got_v[k] || got_w[k] !== exp_word(page, k)) begin
        bad++;
        if (first_bad < 0) first_bad = k;
      end
    end
    if (bad != 0)
      $display("FAIL %s word %0d actual=%h expected=%h", req, first_bad,
               got_w[first_bad], exp_word(page, first_bad));
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic do_reset(input logic mm, input logic req);
    rst_n      = 1'b0;
    mmap_sel   = mm;
    forced_req = req;
    noise_en   = 1'b0;
    force_set  = 1'b0;
    ws_we      = 1'b0;
    ws_val     = '0;
    page_sel   = '0;
    repeat (3) @(negedge clk);
    clear_mon();
    rst_n = 1'b1;
  endtask

  task automatic forced_boot(input int page, input int ws, input bit noisy);
    string tag;
    @(negedge clk);
    ws_we = 1'b1; ws_val = 3'(ws);
    @(negedge clk);
    ws_we = 1'b0;
    page_sel = 3'(page);
    clear_mon();
    force_set = 1'b1;
    @(negedge clk);
    force_set = 1'b0;
    noise_en  = noisy;
    tag = $sformatf("R3 page %0d ws %0d", page, ws);
    wait_done(tag);
    noise_en = 1'b0;
    check_words(page, "R4 R6 forced words");
    chk(strobe_cnt == 3 * N * (ws + 1), "R5 strobe cycles", strobe_cnt, 3 * N * (ws + 1));
    chk(overlap_cnt == 0 && split_cnt == 0, "R7 grant/strobe overlap", overlap_cnt + split_cnt, 0);
    chk(exec_bad == 0, "R8 exec during boot", exec_bad, 0);
    @(negedge clk);
    chk(exec_en == 1'b1, "R8 exec after done", int'(exec_en), 1);
  endtask

  initial begin
    finished = 1'b0;
    n_run = 0;
    n_fail = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; mmap_sel = 1'b0; forced_req = 1'b0; noise_en = 1'b0;
    force_set = 1'b0; ws_we = 1'b0; ws_val = '0; page_sel = '0;
    clear_mon();
    repeat (2) @(negedge clk);
    chk(boot_sel_n && rd_n && !pm_we && !boot_done && !bus_grant && !exec_en,
        "R1 reset state", int'({boot_sel_n, rd_n, pm_we, boot_done, bus_grant, exec_en}), 6'b110000);

    // R1 automatic boot from page 0 with the default wait setting of 7
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    chk(!boot_sel_n && ext_addr == 0 && ext_addr_hi == 0, "R1 auto boot begins",
        int'(boot_sel_n), 0);
    wait_done("R1 auto boot done");
    check_words(0, "R1 R6 auto words");
    chk(strobe_cnt == 3 * N * 8, "R5 default wait 7", strobe_cnt, 3 * N * 8);
    chk(bad_addr == 0, "R6 pm_addr range", bad_addr, 0);

    // R2 no boot with memory map set
    do_reset(1'b1, 1'b0);
    repeat (300) @(negedge clk);
    chk(strobe_cnt == 0, "R2 mmap=1 no reads", strobe_cnt, 0);
    chk(exec_en == 1'b1, "R2 mmap=1 exec", int'(exec_en), 1);

    // R2 pending bus request suppresses the boot
    do_reset(1'b0, 1'b1);
    repeat (20) @(negedge clk);
    chk(bus_grant == 1'b1, "R2 grant at reset", int'(bus_grant), 1);
    forced_req = 1'b0;
    repeat (300) @(negedge clk);
    chk(strobe_cnt == 0, "R2 bus_req no reads", strobe_cnt, 0);
    chk(exec_en == 1'b1, "R2 bus_req exec", int'(exec_en), 1);

    // directed corners: wait 0 on top page, then random pages with bus noise
    forced_boot(7, 0, 1'b0);
    clear_mon();
    repeat (300) @(negedge clk);
    chk(strobe_cnt == 0 && done_cnt == 0, "R3 force bit self-clears", strobe_cnt, 0);
    forced_boot(5, 3, 1'b1);
    chk(grant_cnt > 0, "R7 grants seen mid-boot", grant_cnt, 1);
    for (int t = 0; t < 5; t++) begin
      forced_boot(int'($urandom % 8), int'($urandom % 8), 1'b1);
    end

    // R3 force request made while the bus is held starts after release
    forced_req = 1'b1;
    repeat (3) @(negedge clk);
    page_sel = 3'd6;
    clear_mon();
    force_set = 1'b1;
    @(negedge clk);
    force_set = 1'b0;
    repeat (20) @(negedge clk);
    chk(strobe_cnt == 0, "R7 no reads while granted", strobe_cnt, 0);
    forced_req = 1'b0;
    wait_done("R3 deferred force");
    check_words(6, "R3 R4 deferred words");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule